// File: doc/BRIEF.md
# Directory Entry Cache

A two-entry cache that sits beside a page-table walker and keeps copies of the directory-level entries it read most recently. When the translation cache misses and the walker finds the needed directory entry here, it skips the directory read. One page-table read is then enough to form the physical address. Lookup is combinational. The walker presents a linear address and gets back, in the same cycle, a hit flag and the cached 32-bit entry. Bits 31:22 of the address select the directory slot.

The walker fills the cache after each directory read it performs. It refreshes the cached copy whenever it writes the accessed flag back into a directory entry. The cache is off after reset. It is switched on by bit 4 of an 8-bit configuration register. Loading the directory base register or flushing the translation cache empties it.

Top module: `dir_entry_cache`

## Requirements
- R1: After reset the cache is disabled and every lookup reports a miss with a zero entry.
- R2: A configuration write loads the enable from `cfg_wdata[4]`. Bit 4 set means enabled and bit 4 clear means disabled. The other seven bits have no effect. The new state applies from the cycle after the write.
- R3: While disabled, every lookup misses and fill requests store nothing. Entries present when the cache is disabled are dropped, so after re-enabling, lookups miss until new fills arrive.
- R4: A lookup hits in the same cycle when `lk_addr[31:22]` equals the tag of a valid entry. On a hit, `lk_entry` carries the stored entry. Address bits 21:0 do not affect the result.
- R5: A fill while enabled stores `fill_entry` under tag `fill_addr[31:22]`, and a lookup hits on it from the next cycle.
- R6: A fill with a new tag goes to an empty entry (entry 0 first). If both entries are valid, it goes to the least recently used one. A lookup hit or a fill marks its entry as most recently used.
- R7: A fill whose tag is already cached overwrites that entry, so no tag is ever held twice.
- R8: A directory base write or a translation-cache flush invalidates both entries from the next cycle. This takes priority over a fill in the same cycle.
- R9: An accessed-flag write-back replaces the data of the entry holding `acc_addr[31:22]`. It allocates nothing when the tag is absent and leaves the replacement order unchanged. A fill to the same entry in the same cycle wins.
- R10: On a miss, `lk_entry` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data; bit 4 is the enable |
| dirbase_wr | input | 1 | Directory base register written |
| tlb_flush | input | 1 | Translation cache flushed |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Linear address to look up |
| lk_hit | output | 1 | Lookup hit |
| lk_entry | output | 32 | Cached directory entry on a hit, zero otherwise |
| fill_req | input | 1 | Walker has read a directory entry |
| fill_addr | input | 32 | Linear address of that walk |
| fill_entry | input | 32 | Directory entry read |
| acc_upd | input | 1 | Walker wrote the accessed flag back to a directory entry |
| acc_addr | input | 32 | Linear address of that write-back |
| acc_entry | input | 32 | Directory entry as written back |

## Verification
The assertions check several properties on every cycle. A disabled cache never hits, and a miss returns zero. At most one entry matches any address. A fill or write-back lands in the following cycle, and an invalidation empties the entries. The replacement bit always points away from the last entry touched, and the enable follows configuration writes. Only the bench's scenarios show the choice of victim across long sequences and the stale-entry behaviour around disable and re-enable. The same applies to collisions between fills, write-backs, lookups and flushes in one cycle. The bench compares each of these against an arithmetic model.

// File: rtl/dec_pkg.sv
// Shared constants for the directory entry cache.
// Assumes exactly two ways, so one bit names a way and one bit tracks recency.
package dec_pkg;
    localparam int NUM_WAYS = 2;
    typedef logic way_idx_t;
endpackage

// File: rtl/dec_cfg.sv
// Enable register of the directory entry cache.
// Loads its state from one bit of a configuration write; cleared by reset.
module dec_cfg #(
    parameter int CFG_W  = 8,
    parameter int EN_BIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             en
);
    // Hold the enable bit; reset leaves the cache off.
    always_ff @(posedge clk) begin
        if (!rst_n)      en <= 1'b0;
        else if (cfg_we) en <= cfg_wdata[EN_BIT];
    end

    p_en_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> en == $past(cfg_wdata[EN_BIT]));
    p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(en));
endmodule

// File: rtl/dec_way.sv
// One entry of the directory entry cache: valid bit, tag, stored entry.
// Assumes the caller never asserts wr_en or upd_en together with clr.
module dec_way #(
    parameter int TAG_W  = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              upd_en,
    input  logic [DATA_W-1:0] upd_data,
    output logic              valid,
    output logic [TAG_W-1:0]  tag,
    output logic [DATA_W-1:0] data
);
    // Valid flag: cleared on reset or invalidate, set by an allocation.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) valid <= 1'b0;
        else if (wr_en)    valid <= 1'b1;
    end

    // Tag and data: a fill writes both, a write-back refreshes data only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag  <= '0;
            data <= '0;
        end else if (wr_en) begin
            tag  <= wr_tag;
            data <= wr_data;
        end else if (upd_en) begin
            data <= upd_data;
        end
    end

    p_fill_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> valid && tag == $past(wr_tag) && data == $past(wr_data));
    p_upd_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !wr_en && !clr) |=> data == $past(upd_data) && $stable(tag) && $stable(valid));
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !valid);
endmodule

// File: rtl/dec_lru.sv
// Recency tracker for two ways: one bit naming the least recently used way.
// Assumes touch_way is the way just used; the other way becomes the victim.
module dec_lru
    import dec_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     touch_en,
    input  way_idx_t touch_way,
    output way_idx_t lru
);
    // Point at the way not touched most recently.
    always_ff @(posedge clk) begin
        if (!rst_n)        lru <= 1'b0;
        else if (touch_en) lru <= ~touch_way;
    end

    p_lru_away_r6: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> lru != $past(touch_way));
    p_lru_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !touch_en |=> $stable(lru));
endmodule

// File: rtl/dir_entry_cache.sv
// Two-entry cache of directory entries for a page-table walker.
// Lookup is combinational on linear bits [ADDR_W-1:TAG_LSB]; fills, accessed-flag
// write-backs and invalidations take effect at the next clock edge.
// Assumes the walker fills only with entries it has just read from memory.
module dir_entry_cache
    import dec_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int TAG_LSB = 22,
    parameter int DATA_W  = 32,
    parameter int CFG_W   = 8,
    parameter int EN_BIT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              dirbase_wr,
    input  logic              tlb_flush,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_entry,
    input  logic              fill_req,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_entry,
    input  logic              acc_upd,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_entry
);
    localparam int TAG_W = ADDR_W - TAG_LSB;

    logic                en;
    logic                inval;
    logic                fill_go;
    logic                acc_go;
    logic [TAG_W-1:0]    lk_tag, fill_tag, acc_tag;
    logic [NUM_WAYS-1:0] way_v;
    logic [TAG_W-1:0]    way_tag  [NUM_WAYS];
    logic [DATA_W-1:0]   way_data [NUM_WAYS];
    logic [NUM_WAYS-1:0] lk_match, fill_match, acc_match;
    logic [NUM_WAYS-1:0] fill_sel, upd_sel;
    way_idx_t            lru, victim, hit_way;

    assign lk_tag   = lk_addr[ADDR_W-1:TAG_LSB];
    assign fill_tag = fill_addr[ADDR_W-1:TAG_LSB];
    assign acc_tag  = acc_addr[ADDR_W-1:TAG_LSB];

    dec_cfg #(.CFG_W(CFG_W), .EN_BIT(EN_BIT)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .en(en)
    );

    // Disabling counts as invalidation so re-enabling starts empty.
    assign inval   = dirbase_wr || tlb_flush || !en;
    assign fill_go = fill_req && !inval;
    assign acc_go  = acc_upd && !inval;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        // Tag compares for the three address inputs.
        always_comb begin
            lk_match[w]   = way_v[w] && (way_tag[w] == lk_tag);
            fill_match[w] = way_v[w] && (way_tag[w] == fill_tag);
            acc_match[w]  = way_v[w] && (way_tag[w] == acc_tag);
            fill_sel[w]   = fill_go && (victim == way_idx_t'(w));
            upd_sel[w]    = acc_go && acc_match[w];
        end

        dec_way #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_way (
            .clk(clk), .rst_n(rst_n), .clr(inval),
            .wr_en(fill_sel[w]), .wr_tag(fill_tag), .wr_data(fill_entry),
            .upd_en(upd_sel[w]), .upd_data(acc_entry),
            .valid(way_v[w]), .tag(way_tag[w]), .data(way_data[w])
        );
    end

    // Victim: a way already holding the tag, else the lowest empty way, else the LRU way.
    always_comb begin
        victim = lru;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!way_v[w]) victim = way_idx_t'(w);
        end
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (fill_match[w]) victim = way_idx_t'(w);
        end
    end

    // Lookup result: hit flag, hit way and the selected entry (zero on a miss).
    always_comb begin
        lk_hit   = en && lk_req && (|lk_match);
        hit_way  = 1'b0;
        lk_entry = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (lk_match[w]) hit_way = way_idx_t'(w);
            if (lk_hit && lk_match[w]) lk_entry = lk_entry | way_data[w];
        end
    end

    dec_lru u_lru (
        .clk(clk), .rst_n(rst_n),
        .touch_en(fill_go || (lk_hit && !inval)),
        .touch_way(fill_go ? victim : hit_way),
        .lru(lru)
    );

    p_off_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !lk_hit);
    p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_entry == '0);
    p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
    p_inval_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dirbase_wr || tlb_flush) |=> way_v == '0);
endmodule

// File: tb/tb_dir_entry_cache.sv
// Self-checking bench: directed cases plus a long arithmetic sweep over a
// three-tag working set, compared against a model written from the requirements.
module tb_dir_entry_cache;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        dirbase_wr = 1'b0, tlb_flush = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_hit;
    logic [31:0] lk_entry;
    logic        fill_req = 1'b0;
    logic [31:0] fill_addr = '0, fill_entry = '0;
    logic        acc_upd = 1'b0;
    logic [31:0] acc_addr = '0, acc_entry = '0;

    int checks = 0;
    int fails  = 0;

    // Model state.
    logic        m_en;
    logic        m_v [2];
    logic [9:0]  m_tag [2];
    logic [31:0] m_data [2];
    logic        m_lru;

    always #(CLK_P/2) clk = ~clk;

    dir_entry_cache dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .dirbase_wr(dirbase_wr), .tlb_flush(tlb_flush),
        .lk_req(lk_req), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_entry(lk_entry),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_entry(fill_entry),
        .acc_upd(acc_upd), .acc_addr(acc_addr), .acc_entry(acc_entry)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic mmatch(int w, logic [31:0] a);
        return m_v[w] && (m_tag[w] == a[31:22]);
    endfunction

    // Advance the model by one clock edge using the inputs now applied.
    task automatic model_edge();
        logic inv, fgo, hit, vic;
        inv = dirbase_wr || tlb_flush || !m_en;
        hit = m_en && lk_req && (mmatch(0, lk_addr) || mmatch(1, lk_addr));
        fgo = fill_req && !inv;
        if (inv) begin
            m_v[0] = 1'b0;
            m_v[1] = 1'b0;
        end else begin
            if (hit) m_lru = mmatch(0, lk_addr) ? 1'b1 : 1'b0;
            if (acc_upd) begin
                for (int w = 0; w < 2; w++)
                    if (mmatch(w, acc_addr)) m_data[w] = acc_entry;
            end
            if (fgo) begin
                if (mmatch(0, fill_addr))      vic = 1'b0;
                else if (mmatch(1, fill_addr)) vic = 1'b1;
                else if (!m_v[0])              vic = 1'b0;
                else if (!m_v[1])              vic = 1'b1;
                else                           vic = m_lru;
                m_v[vic]    = 1'b1;
                m_tag[vic]  = fill_addr[31:22];
                m_data[vic] = fill_entry;
                m_lru       = ~vic;
            end
        end
        if (cfg_we) m_en = cfg_wdata[4];
    endtask

    // Check the lookup outputs mid-cycle, clock once, then clear the strobes.
    task automatic step(string req);
        logic        eh;
        logic [31:0] ee;
        #(CLK_P/4);
        eh = m_en && lk_req && (mmatch(0, lk_addr) || mmatch(1, lk_addr));
        ee = '0;
        if (eh) ee = mmatch(0, lk_addr) ? m_data[0] : m_data[1];
        check(req, "hit", 32'(lk_hit), 32'(eh));
        check(eh ? req : "R10", "entry", lk_entry, ee);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cfg_we = 0; dirbase_wr = 0; tlb_flush = 0; lk_req = 0; fill_req = 0; acc_upd = 0;
    endtask

    task automatic look(logic [31:0] a, string req);
        lk_req = 1; lk_addr = a; step(req);
    endtask

    task automatic fill(logic [31:0] a, logic [31:0] d, string req);
        fill_req = 1; fill_addr = a; fill_entry = d; step(req);
    endtask

    function automatic logic [31:0] tadr(int t, int lo);
        return {10'(t), 22'(lo)};
    endfunction

    initial begin : watchdog
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        m_en = 0; m_lru = 0;
        for (int w = 0; w < 2; w++) begin m_v[w] = 0; m_tag[w] = '0; m_data[w] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: disabled after reset.
        look(tadr(5, 1), "R1");
        // R3: a fill while disabled is not kept.
        fill(tadr(5, 0), 32'hA5A5_0001, "R3");
        // R2: all bits except bit 4 set leaves the cache off.
        cfg_we = 1; cfg_wdata = 8'hEF; step("R2");
        fill(tadr(5, 0), 32'hA5A5_0002, "R2");
        look(tadr(5, 0), "R2");
        cfg_we = 1; cfg_wdata = 8'h10; step("R2");
        look(tadr(5, 0), "R3");
        // R5: fill then hit next cycle; R4: low bits ignored.
        fill(tadr(5, 3), 32'h1111_0001, "R5");
        look(tadr(5, 32'h3F_FFFF), "R4");
        look(tadr(6, 0), "R4");
        // R6: second tag into the empty way, touch tag 5, then a third tag evicts tag 6.
        fill(tadr(6, 7), 32'h2222_0002, "R6");
        look(tadr(5, 9), "R6");
        fill(tadr(7, 1), 32'h3333_0003, "R6");
        look(tadr(6, 0), "R6");
        look(tadr(5, 0), "R6");
        look(tadr(7, 0), "R6");
        // R7: refill of a cached tag overwrites in place.
        fill(tadr(7, 4), 32'h3333_0004, "R7");
        look(tadr(7, 0), "R7");
        look(tadr(5, 0), "R7");
        // R9: write-back refreshes data; absent tag allocates nothing.
        acc_upd = 1; acc_addr = tadr(5, 2); acc_entry = 32'h1111_0021; step("R9");
        look(tadr(5, 0), "R9");
        acc_upd = 1; acc_addr = tadr(9, 2); acc_entry = 32'h9999_0009; step("R9");
        look(tadr(9, 0), "R9");
        // R8: flush beats a same-cycle fill; directory base write empties too.
        tlb_flush = 1; fill_req = 1; fill_addr = tadr(8, 0); fill_entry = 32'h8888_0008; step("R8");
        look(tadr(8, 0), "R8");
        look(tadr(5, 0), "R8");
        fill(tadr(4, 0), 32'h4444_0004, "R8");
        dirbase_wr = 1; step("R8");
        look(tadr(4, 0), "R8");
        // R3: entries dropped on disable stay gone after re-enable.
        fill(tadr(3, 0), 32'h3030_0003, "R3");
        cfg_we = 1; cfg_wdata = 8'h00; step("R3");
        look(tadr(3, 0), "R3");
        cfg_we = 1; cfg_wdata = 8'h10; step("R3");
        look(tadr(3, 0), "R3");

        // Sweep: mixed operations over a three-tag working set.
        for (int i = 0; i < 3000; i++) begin
            int op, t;
            op = (i * 7 + i / 3) % 10;
            t  = 20 + (i * 5 + i / 7) % 3;
            lk_addr = tadr(20 + (i * 3 + i / 5) % 3, i * 977);
            case (op)
                0, 1, 2, 3: lk_req = 1;
                4, 5: begin fill_req = 1; fill_addr = tadr(t, i); fill_entry = 32'(i * 40503 + 1); end
                6: begin acc_upd = 1; acc_addr = tadr(t, i * 3); acc_entry = 32'(i * 2654435 + 7); lk_req = 1; end
                7: begin
                    lk_req = 1; fill_req = 1; fill_addr = tadr(t, i); fill_entry = 32'(i * 31 + 5);
                    acc_upd = (i % 2 == 0); acc_addr = tadr(t, 0); acc_entry = 32'(i * 17);
                end
                8: begin
                    lk_req = 1;
                    if (i % 5 == 0) begin dirbase_wr = (i % 2 == 0); tlb_flush = (i % 2 == 1); end
                end
                default: begin
                    cfg_we = 1;
                    cfg_wdata = 8'(i) & 8'hEF | ((i % 11 != 0) ? 8'h10 : 8'h00);
                    lk_req = 1;
                end
            endcase
            step("R4");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule